// File: doc/BRIEF.md
# Microstep Phase Sequencer

This block generates the phase current setpoints for a two-phase bipolar stepper motor. A step input is sampled on the system clock, and each rising edge moves an electrical position index one step clockwise or counter-clockwise, as the direction input selects. From that index the block derives a signed setpoint for each of the two windings, as a sign bit plus a magnitude in percent. The magnitude is then scaled by a torque code. A downstream current regulator turns these setpoints into chopped bridge drive. That regulator, the current sensing and the bridge are outside this block.

There are four resolutions: full step with both windings on, half step, eighth step and sixteenth step. Each has its own magnitude table and its own home position. The index always runs at the finest resolution, 64 positions per electrical cycle, and coarser modes move it by larger strides. The synchronous active-low reset puts the index at the home position for the selected mode. An active-low home flag reports when the index is at home. Disabling the block silences the outputs and raises an off flag, but the index keeps following the step input, so output resumes at the position reached while disabled.

Top module: `microstep_sequencer`

## Requirements
- R1: The mode input selects the stride per step edge. Code 00 is full step: 4 steps per electrical cycle, and 00 is the all-low default. Code 01 is half step: 8 steps. Code 11 is eighth step: 32 steps. Code 10 is sixteenth step: 64 steps. After a whole cycle of steps in one direction, the outputs are back at home.
- R2: While rst_n is low, the outputs show the home state of the selected mode. In full step this is A = +100 and B = -100. In every other mode it is A = +100 and B = 0. home_n_o is low whenever the position is the home of the current mode, including while reset is held.
- R3: While rst_n is low, step and direction changes have no effect. Reset release alone does not advance the position, even with the step input already high. The first step rising edge after release moves to the position that follows home.
- R4: Magnitudes per mode, listed from 0 to 90 electrical degrees. Full step is always 100. Half step is 100, 71, 0. Eighth step is 100, 98, 92, 83, 71, 56, 38, 20, 0. Sixteenth step is 100, 100, 98, 96, 92, 88, 83, 77, 71, 63, 56, 47, 38, 29, 20, 10, 0. The other quadrants mirror these values with cosine symmetry.
- R5: With dir_i low (clockwise), phase A leads phase B by a quarter cycle. A follows a cosine shape and B follows a sine shape of the advancing angle. Full step from home goes (+100,-100), (+100,+100), (-100,+100), (-100,-100), then back to home.
- R6: With dir_i high (counter-clockwise), the same sequence is walked backwards and wraps through the home position. Full step from home goes to (-100,-100).
- R7: The torque code scales both magnitudes to floor(m * p / 100). Code 00 gives p = 100, 01 gives 75, 10 gives 50 and 11 gives 20.
- R8: When en_i is low, off_o is 1 and both magnitudes and both signs are 0, but step edges still move the position. When en_i returns high, the outputs show the position reached, with no restart.
- R9: A magnitude of 0 is always reported with the sign bit low.
- R10: Each rising edge of step_i advances the position exactly once, however long step_i stays high. The new setpoints appear one clock after the clock edge that first samples step_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset to the mode's home position |
| step_i | input | 1 | Step request; each rising edge moves one step |
| dir_i | input | 1 | Direction: 0 clockwise, 1 counter-clockwise |
| mode_i | input | 2 | Resolution: 00 full, 01 half, 11 eighth, 10 sixteenth |
| torque_i | input | 2 | Torque scale: 00 100%, 01 75%, 10 50%, 11 20% |
| en_i | input | 1 | Output enable; low silences outputs only |
| a_neg_o | output | 1 | Phase A setpoint sign, 1 for negative |
| a_mag_o | output | 7 | Phase A setpoint magnitude in percent |
| b_neg_o | output | 1 | Phase B setpoint sign, 1 for negative |
| b_mag_o | output | 7 | Phase B setpoint magnitude in percent |
| off_o | output | 1 | 1 while outputs are forced off |
| home_n_o | output | 1 | Low while the position is the home of the current mode |

## Verification
Each resolution is walked through a whole electrical cycle clockwise, and the sixteenth-step walk is then reversed back through home. This separates the four tables, the strides and the cosine and sine quadrant folding, and it catches a swapped lead or lag between the phases. Resets taken with the step line active, and with the mode changed while reset is held, tell a correct home position apart from a spurious first advance. A step held high over many clocks tells edge detection apart from level detection. The torque codes are applied at a 71% point, where floor rounding and the scale factor show. A disabled stretch with steps in it tells output gating apart from freezing the counter.

// File: rtl/mstep_pkg.sv
// Package: shared widths, mode encoding and magnitude tables for the
// microstep sequencer. Assumes 64 index positions per electrical cycle
// and magnitudes expressed in whole percent (0..100).
package mstep_pkg;

    localparam int IDX_W   = 6;                 // index width
    localparam int POS_N   = 2 ** IDX_W;        // positions per cycle
    localparam int QUARTER = POS_N / 4;         // positions per quadrant
    localparam int R_W     = IDX_W - 2;         // in-quadrant offset width
    localparam int Q_W     = R_W + 1;           // folded quadrant position 0..QUARTER
    localparam int MAG_W   = 7;                 // magnitude width, 0..100
    localparam int PROD_W  = 2 * MAG_W;         // scaled product width
    localparam int FULL_PCT = 100;

    typedef enum logic [1:0] {
        MODE_FULL      = 2'b00,
        MODE_HALF      = 2'b01,
        MODE_SIXTEENTH = 2'b10,
        MODE_EIGHTH    = 2'b11
    } mode_e;

    // Home index: full step sits at -45 degrees so both windings are on.
    function automatic logic [IDX_W-1:0] home_idx(mode_e m);
        return (m == MODE_FULL) ? IDX_W'(POS_N - QUARTER / 2) : '0;
    endfunction

    // Index stride per step edge for each resolution.
    function automatic logic [IDX_W-1:0] step_stride(mode_e m);
        case (m)
            MODE_FULL:      return IDX_W'(QUARTER);
            MODE_HALF:      return IDX_W'(QUARTER / 2);
            MODE_EIGHTH:    return IDX_W'(2);
            default:        return IDX_W'(1);
        endcase
    endfunction

    // Sixteenth-step cosine table over one quadrant, q = 0..16.
    function automatic logic [MAG_W-1:0] fine_mag(logic [Q_W-1:0] q);
        case (q)
            5'd0, 5'd1: return 7'd100;
            5'd2:  return 7'd98;
            5'd3:  return 7'd96;
            5'd4:  return 7'd92;
            5'd5:  return 7'd88;
            5'd6:  return 7'd83;
            5'd7:  return 7'd77;
            5'd8:  return 7'd71;
            5'd9:  return 7'd63;
            5'd10: return 7'd56;
            5'd11: return 7'd47;
            5'd12: return 7'd38;
            5'd13: return 7'd29;
            5'd14: return 7'd20;
            5'd15: return 7'd10;
            default: return 7'd0;
        endcase
    endfunction

    // Eighth-step table, indexed by half the folded position (0..8).
    function automatic logic [MAG_W-1:0] coarse_mag(logic [Q_W-2:0] h);
        case (h)
            4'd0: return 7'd100;
            4'd1: return 7'd98;
            4'd2: return 7'd92;
            4'd3: return 7'd83;
            4'd4: return 7'd71;
            4'd5: return 7'd56;
            4'd6: return 7'd38;
            4'd7: return 7'd20;
            default: return 7'd0;
        endcase
    endfunction

    // Torque code to percentage.
    function automatic logic [MAG_W-1:0] torque_pct(logic [1:0] code);
        case (code)
            2'b00:   return 7'd100;
            2'b01:   return 7'd75;
            2'b10:   return 7'd50;
            default: return 7'd20;
        endcase
    endfunction

    // Floor of magnitude times percentage over 100.
    function automatic logic [MAG_W-1:0] apply_pct(logic [MAG_W-1:0] mag,
                                                   logic [MAG_W-1:0] pct);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(mag) * PROD_W'(pct);
        return MAG_W'(prod / PROD_W'(FULL_PCT));
    endfunction

endpackage

// File: rtl/mstep_index.sv
// Position index: detects step rising edges on the system clock and moves a
// 64-position index by the mode's stride in the chosen direction.
// Assumes step_i is already synchronous to clk. Reset is synchronous and
// active low and also serves as the functional home command.
module mstep_index
    import mstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  mode_e            mode_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             at_home_o
);

    logic             step_q;
    logic             step_rise;
    logic [IDX_W-1:0] idx_q;

    // Track the step line so only a low-to-high change counts; tracking
    // continues in reset so a line held high is not seen as a new edge.
    always_ff @(posedge clk) begin
        step_q <= step_i;
    end

    assign step_rise = step_i & ~step_q;

    // Move the index on each step edge; reset parks it at the mode's home.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= home_idx(mode_i);
        end else if (step_rise) begin
            idx_q <= dir_i ? (idx_q - step_stride(mode_i))
                           : (idx_q + step_stride(mode_i));
        end
    end

    assign idx_o     = idx_q;
    assign at_home_o = (idx_q == home_idx(mode_i));

    AST_RELEASE_AT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> idx_q == home_idx(mode_e'($past(mode_i)))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_rise)) |-> $stable(idx_q)); // R10

    AST_EDGE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_rise)) |-> !$stable(idx_q)); // R1

endmodule

// File: rtl/mstep_phase.sv
// Phase lookup: turns an electrical angle index into a cosine-shaped signed
// magnitude for the selected resolution. Folds the angle into one quadrant
// so only quarter-period tables are stored. Assumes the caller offsets the
// angle for the lagging phase.
module mstep_phase
    import mstep_pkg::*;
(
    input  logic [IDX_W-1:0] angle_i,
    input  mode_e            mode_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);

    logic [1:0]       quad;
    logic [R_W-1:0]   offs;
    logic [Q_W-1:0]   fold;
    logic [MAG_W-1:0] mag;

    assign quad = angle_i[IDX_W-1 -: 2];
    assign offs = angle_i[R_W-1:0];

    // Mirror odd quadrants so the table is read from the zero-degree end.
    always_comb begin
        if (quad[0]) fold = Q_W'(QUARTER) - Q_W'(offs);
        else         fold = Q_W'(offs);
    end

    // Pick the table for the active resolution.
    always_comb begin
        case (mode_i)
            MODE_FULL:      mag = MAG_W'(FULL_PCT);
            MODE_SIXTEENTH: mag = fine_mag(fold);
            default:        mag = coarse_mag(fold[Q_W-1:1]);
        endcase
    end

    assign mag_o = mag;
    // Cosine is negative in the second and third quadrants; zero stays positive.
    assign neg_o = (quad == 2'd1 || quad == 2'd2) && (mag != '0);

endmodule

// File: rtl/mstep_torque.sv
// Torque stage: scales a phase magnitude by the torque code and silences it
// when the outputs are disabled. Assumes magnitudes of at most 100.
module mstep_torque
    import mstep_pkg::*;
(
    input  logic [MAG_W-1:0] mag_i,
    input  logic             neg_i,
    input  logic [1:0]       torque_i,
    input  logic             en_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);

    logic [MAG_W-1:0] scaled;

    // Floor-scale by the selected percentage.
    always_comb begin
        scaled = apply_pct(mag_i, torque_pct(torque_i));
    end

    // Gate to zero when disabled; drop the sign when the result is zero.
    always_comb begin
        if (!en_i) begin
            mag_o = '0;
            neg_o = 1'b0;
        end else begin
            mag_o = scaled;
            neg_o = neg_i && (scaled != '0);
        end
    end

endmodule

// File: rtl/microstep_sequencer.sv
// Microstep phase sequencer top: one shared position index feeds two phase
// lookups a quarter cycle apart (A cosine, B sine), each followed by torque
// scaling and enable gating. Assumes all inputs are synchronous to clk.
module microstep_sequencer
    import mstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       torque_i,
    input  logic             en_i,
    output logic             a_neg_o,
    output logic [MAG_W-1:0] a_mag_o,
    output logic             b_neg_o,
    output logic [MAG_W-1:0] b_mag_o,
    output logic             off_o,
    output logic             home_n_o
);

    localparam int PHASES = 2;

    mode_e                        mode;
    logic [IDX_W-1:0]             idx;
    logic                         at_home;
    logic [PHASES-1:0][MAG_W-1:0] out_mag;
    logic [PHASES-1:0]            out_neg;

    assign mode = mode_e'(mode_i);

    mstep_index u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .dir_i     (dir_i),
        .mode_i    (mode),
        .idx_o     (idx),
        .at_home_o (at_home)
    );

    // One lookup and torque stage per winding, each lagging by a quarter cycle.
    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        localparam logic [IDX_W-1:0] LAG = IDX_W'(ph * QUARTER);
        logic [IDX_W-1:0] angle;
        logic [MAG_W-1:0] raw_mag;
        logic             raw_neg;

        assign angle = idx - LAG;

        mstep_phase u_phase (
            .angle_i (angle),
            .mode_i  (mode),
            .mag_o   (raw_mag),
            .neg_o   (raw_neg)
        );

        mstep_torque u_torque (
            .mag_i    (raw_mag),
            .neg_i    (raw_neg),
            .torque_i (torque_i),
            .en_i     (en_i),
            .mag_o    (out_mag[ph]),
            .neg_o    (out_neg[ph])
        );
    end

    assign a_mag_o  = out_mag[0];
    assign a_neg_o  = out_neg[0];
    assign b_mag_o  = out_mag[1];
    assign b_neg_o  = out_neg[1];
    assign off_o    = ~en_i;
    assign home_n_o = ~at_home;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |-> (a_mag_o == '0 && b_mag_o == '0 && !a_neg_o && !b_neg_o)); // R8

    AST_ZERO_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (a_mag_o == '0 |-> !a_neg_o) and (b_mag_o == '0 |-> !b_neg_o)); // R9

    AST_HOME_A_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (!home_n_o && !off_o && torque_i == 2'b00) |-> (a_mag_o == 7'd100 && !a_neg_o)); // R2

    AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_mag_o <= 7'd100) && (b_mag_o <= 7'd100)); // R4

endmodule

// File: tb/microstep_sequencer_tb.sv
// Directed bench for the microstep sequencer: one task per scenario, with
// expected setpoints computed from the requirement tables.
module microstep_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_i;
    logic       dir_i;
    logic [1:0] mode_i;
    logic [1:0] torque_i;
    logic       en_i;
    logic       a_neg_o, b_neg_o, off_o, home_n_o;
    logic [6:0] a_mag_o, b_mag_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_pos  = 0;
    int md       = 0;

    int t16 [0:16] = '{100, 100, 98, 96, 92, 88, 83, 77, 71, 63, 56, 47, 38, 29, 20, 10, 0};
    int t8  [0:8]  = '{100, 98, 92, 83, 71, 56, 38, 20, 0};

    always #4 clk = ~clk;

    microstep_sequencer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_i),
        .dir_i    (dir_i),
        .mode_i   (mode_i),
        .torque_i (torque_i),
        .en_i     (en_i),
        .a_neg_o  (a_neg_o),
        .a_mag_o  (a_mag_o),
        .b_neg_o  (b_neg_o),
        .b_mag_o  (b_mag_o),
        .off_o    (off_o),
        .home_n_o (home_n_o)
    );

    // Mode codes: 0 full, 1 half, 2 sixteenth, 3 eighth.
    function automatic int home_of(int m);
        return (m == 0) ? 56 : 0;
    endfunction

    function automatic int stride_of(int m);
        case (m)
            0: return 16;
            1: return 8;
            3: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int pct_of(int code);
        case (code)
            0: return 100;
            1: return 75;
            2: return 50;
            default: return 20;
        endcase
    endfunction

    function automatic void cos_exp(int ang, int m, output int neg, output int mag);
        int quad, r, q;
        quad = ang / 16;
        r    = ang % 16;
        q    = (quad % 2 == 1) ? 16 - r : r;
        if (m == 0)      mag = 100;
        else if (m == 2) mag = t16[q];
        else             mag = t8[q / 2];
        mag = (mag * pct_of(int'(torque_i))) / 100;
        if (!en_i) mag = 0;
        neg = ((quad == 1 || quad == 2) && mag != 0) ? 1 : 0;
    endfunction

    task automatic report(string tag, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Compare every output against the model at the current position.
    task automatic check_all(string tag);
        int an, am, bn, bm, act, expv;
        cos_exp(exp_pos, md, an, am);
        cos_exp((exp_pos + 48) % 64, md, bn, bm);
        act  = (a_neg_o ? -1 : 1) * int'(a_mag_o) * 1000 + (b_neg_o ? -1 : 1) * int'(b_mag_o)
               + (off_o ? 500000 : 0) + (home_n_o ? 0 : 2000000);
        expv = (an ? -1 : 1) * am * 1000 + (bn ? -1 : 1) * bm
               + (en_i ? 0 : 500000) + (exp_pos == home_of(md) ? 2000000 : 0);
        report($sformatf("%s pos %0d (A*1000+B+off*5e5+home*2e6)", tag, exp_pos), act, expv);
    endtask

    task automatic do_step(int d);
        @(negedge clk);
        dir_i  = d[0];
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        exp_pos = (exp_pos + (d ? -stride_of(md) : stride_of(md)) + 64) % 64;
    endtask

    task automatic enter_reset(int m);
        @(negedge clk);
        rst_n  = 1'b0;
        md     = m;
        mode_i = 2'(m);
        repeat (2) @(negedge clk);
        exp_pos = home_of(m);
    endtask

    task automatic leave_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset_state();
        enter_reset(0);
        check_all("R2 full-step home in reset");
        report("R2 A sign at full home", int'(a_neg_o), 0);
        report("R2 B sign at full home", int'(b_neg_o), 1);
        do_step(0);
        do_step(1);
        exp_pos = home_of(0);
        check_all("R3 steps ignored in reset");
        enter_reset(1);
        check_all("R2 half-step home in reset");
        report("R2 B magnitude at half home", int'(b_mag_o), 0);
    endtask

    task automatic test_full_walk();
        enter_reset(0);
        leave_reset();
        for (int i = 0; i < 4; i++) begin
            do_step(0);
            check_all("R1 R5 full step clockwise");
        end
        report("R1 home flag after full cycle", int'(home_n_o), 0);
        do_step(1);
        check_all("R6 full step counter-clockwise");
        report("R6 A negative after reverse", int'(a_neg_o), 1);
    endtask

    task automatic test_mode_walk(int m, string tag);
        enter_reset(m);
        leave_reset();
        check_all({tag, " home after release"});
        for (int i = 0; i < 64 / stride_of(m); i++) begin
            do_step(0);
            check_all({tag, " clockwise"});
        end
    endtask

    task automatic test_reverse_wrap();
        enter_reset(2);
        leave_reset();
        for (int i = 0; i < 3; i++) begin
            do_step(1);
            check_all("R6 sixteenth wrap backwards");
        end
    endtask

    task automatic test_release_first();
        enter_reset(2);
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R3 no advance on release with step high");
        step_i = 1'b0;
        do_step(0);
        check_all("R3 first edge leaves home");
        report("R3 B after first sixteenth step", int'(b_mag_o), 10);
    endtask

    task automatic test_torque();
        enter_reset(1);
        leave_reset();
        do_step(0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            torque_i = 2'(c);
            @(negedge clk);
            check_all("R7 torque scaling");
        end
        torque_i = 2'b01;
        @(negedge clk);
        report("R7 71 percent at 75 torque", int'(a_mag_o), 53);
        torque_i = 2'b00;
    endtask

    task automatic test_enable();
        enter_reset(1);
        leave_reset();
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check_all("R8 disabled outputs off");
        do_step(0);
        do_step(0);
        check_all("R8 disabled while stepping");
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
        check_all("R8 resume at advanced position");
    endtask

    task automatic test_hold();
        enter_reset(3);
        leave_reset();
        @(negedge clk);
        dir_i  = 1'b0;
        step_i = 1'b1;
        @(negedge clk);
        exp_pos = (exp_pos + stride_of(md)) % 64;
        check_all("R10 setpoint one clock after edge");
        repeat (5) @(negedge clk);
        check_all("R10 held step advances once");
        step_i = 1'b0;
        @(negedge clk);
        check_all("R10 falling edge has no effect");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        step_i   = 1'b0;
        dir_i    = 1'b0;
        mode_i   = 2'b00;
        torque_i = 2'b00;
        en_i     = 1'b1;
        repeat (3) @(negedge clk);
        test_reset_state();
        test_full_walk();
        test_mode_walk(1, "R1 R4 R5 R9 half step");
        test_mode_walk(3, "R1 R4 R5 R9 eighth step");
        test_mode_walk(2, "R1 R4 R5 R9 sixteenth step");
        test_reverse_wrap();
        test_release_first();
        test_torque();
        test_enable();
        test_hold();
        finish_run();
    end

endmodule